// File: doc/BRIEF.md
# Coprocessor Integer Compare Flag Unit

This block holds a small bank of 64-bit coprocessor registers and, on request, compares two of them by subtracting the second from the first. It returns the negative, zero, carry and overflow flags to the host core, packed into the top four bits of a 32-bit condition word. The word comes out of a register and is marked by a one-cycle valid pulse. The compare works either as a signed 32-bit compare on the low halves or as a full 64-bit compare.

The host starts a compare by raising `start` for one cycle. In that same cycle it presents an instruction word and a mode opcode. The two source register numbers are taken from fixed fields of the instruction word. A simple write port loads the register bank. An opcode that names no compare mode still produces a valid pulse, but with an all-zero word and the `err` flag raised.

Top module: `cmp_flag_unit`

## Requirements
- R1: The condition word carries N in bit 31, Z in bit 30, C in bit 29 and V in bit 28. Bits 27 down to 0 are always zero.
- R2: With r = a - b, where a is the first source and b is the second, Z is 1 exactly when r is zero over the selected width.
- R3: N equals the most significant bit of r over the selected width.
- R4: C is 1 when any of the following holds: a is negative and b is non-negative; a is negative and r is non-negative; b is non-negative and r is non-negative. Signs are taken at the top bit of the selected width.
- R5: V is 1 when a is negative, b is non-negative and r is non-negative, or when a is non-negative, b is negative and r is negative. The same rule uses 32-bit signs in 32-bit mode.
- R6: Opcode 2'b00 selects 32-bit mode. In this mode only bits 31:0 of each source register are used, and the upper halves have no effect.
- R7: Opcode 2'b01 selects 64-bit mode, which uses all 64 bits of each source register.
- R8: The first source index comes from instr[19:16] and the second from instr[3:0]. All other instruction bits have no effect.
- R9: When `start` is sampled high at a clock edge, `valid` and the new `status` appear after that edge. Each start gives exactly one valid cycle. `status` holds its value until the next start.
- R10: Opcodes 2'b10 and 2'b11 are unknown. They give a valid cycle with `err` high and `status` equal to zero. `err` is low on all other cycles.
- R11: While reset is applied and after it is released, `status` is zero and `valid` and `err` are low until the first start.
- R12: A write is seen by any compare started from the next cycle on. A compare started in the same cycle as a write to one of its sources uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register bank write enable |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | 64 | Write data |
| start | input | 1 | Start a compare this cycle |
| opcode | input | 2 | Mode: 00 = 32-bit compare, 01 = 64-bit compare, others unknown |
| instr | input | 32 | Instruction word holding the source register numbers |
| status | output | 32 | Packed condition word |
| valid | output | 1 | One-cycle pulse marking a new condition word |
| err | output | 1 | Unknown opcode, raised together with valid |

## Verification
Every result (`valid`, `status`, `err`) is due in the cycle that follows the rising edge that samples `start`. The register read, the subtraction and the flag packing all complete before that edge, so there is exactly one register stage between the stimulus and its result.

The driver raises `start` on a falling edge and pushes the expected word onto a queue at that moment. The monitor samples the outputs on every falling edge and pops one entry for each `valid` it sees. As a result, a late pulse, a missing pulse or an extra pulse each shows up as a mismatch or as an unexpected item.

Held values and the same-cycle write-then-compare order are checked on those same falling-edge samples.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  parameter int DATA_W    = 64;
  parameter int HALF_W    = 32;
  parameter int REG_DEPTH = 16;
  parameter int IDX_W     = $clog2(REG_DEPTH);
  parameter int STAT_W    = 32;
  parameter int INSTR_W   = 32;
  parameter int OP_W      = 2;
  parameter int NUM_MODES = 2;

  // instruction field positions for the source register numbers
  parameter int SRC_A_LSB = 16;
  parameter int SRC_B_LSB = 0;

  // flag positions inside the condition word
  parameter int N_POS = 31;
  parameter int Z_POS = 30;
  parameter int C_POS = 29;
  parameter int V_POS = 28;

  parameter logic [OP_W-1:0] OP_CMP32 = 2'b00;
  parameter logic [OP_W-1:0] OP_CMP64 = 2'b01;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cfu_flags_t;

  function automatic logic [STAT_W-1:0] pack_status(input cfu_flags_t f);
    logic [STAT_W-1:0] w;
    w        = '0;
    w[N_POS] = f.n;
    w[Z_POS] = f.z;
    w[C_POS] = f.c;
    w[V_POS] = f.v;
    return w;
  endfunction

endpackage

// File: rtl/cfu_rst_sync.sv
module cfu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/cfu_regfile.sv
module cfu_regfile #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_a_idx,
  input  logic [AW-1:0]    rd_b_idx,
  output logic [WIDTH-1:0] rd_a_data,
  output logic [WIDTH-1:0] rd_b_data
);

  logic [WIDTH-1:0] bank [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      bank[wr_idx] <= wr_data;
    end
  end

  always_comb begin
    rd_a_data = bank[rd_a_idx];
    rd_b_data = bank[rd_b_idx];
  end

endmodule

// File: rtl/cfu_flag_tap.sv
module cfu_flag_tap #(
  parameter int W = 64
) (
  input  logic                     sign_a,
  input  logic                     sign_b,
  input  logic [W-1:0]             diff,
  output cfu_pkg::cfu_flags_t      flags
);

  logic sign_r;

  always_comb begin
    sign_r  = diff[W-1];
    flags.n = sign_r;
    flags.z = (diff == '0);
    flags.c = (sign_a & ~sign_b) | (sign_a & ~sign_r) | (~sign_b & ~sign_r);
    flags.v = (sign_a & ~sign_b & ~sign_r) | (~sign_a & sign_b & sign_r);
  end

endmodule

// File: rtl/cfu_result_reg.sv
module cfu_result_reg
  import cfu_pkg::*;
#(
  parameter int MODES = NUM_MODES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   opcode,
  input  cfu_flags_t        mode_flags [MODES],
  output logic [STAT_W-1:0] status,
  output logic              valid,
  output logic              err
);

  logic [STAT_W-1:0] stat_d, stat_q;
  logic              vld_d, vld_q;
  logic              err_d, err_q;

  always_comb begin
    stat_d = stat_q;
    vld_d  = 1'b0;
    err_d  = 1'b0;
    if (start) begin
      vld_d = 1'b1;
      case (opcode)
        OP_CMP32: stat_d = pack_status(mode_flags[0]);
        OP_CMP64: stat_d = pack_status(mode_flags[1]);
        default: begin
          stat_d = '0;
          err_d  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (start) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  assign status = stat_q;
  assign valid  = vld_q;
  assign err    = err_q;

endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cfu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               start,
  input  logic [OP_W-1:0]    opcode,
  input  logic [INSTR_W-1:0] instr,
  output logic [STAT_W-1:0]  status,
  output logic               valid,
  output logic               err
);

  localparam int MODE_W [NUM_MODES] = '{HALF_W, DATA_W};

  logic              rst_sync_n;
  logic [IDX_W-1:0]  src_a_idx, src_b_idx;
  logic [DATA_W-1:0] src_a, src_b;
  logic [DATA_W-1:0] diff;
  cfu_flags_t        mode_flags [NUM_MODES];
  logic              unused_instr_bits;

  cfu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    src_a_idx = instr[SRC_A_LSB +: IDX_W];
    src_b_idx = instr[SRC_B_LSB +: IDX_W];
  end

  assign unused_instr_bits = ^{instr[INSTR_W-1:SRC_A_LSB+IDX_W],
                               instr[SRC_A_LSB-1:SRC_B_LSB+IDX_W]};

  cfu_regfile #(.DEPTH(REG_DEPTH), .WIDTH(DATA_W)) u_regfile (
    .clk       (clk),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_a_idx  (src_a_idx),
    .rd_b_idx  (src_b_idx),
    .rd_a_data (src_a),
    .rd_b_data (src_b)
  );

  // one shared subtractor; the low half of a full-width difference is the narrow difference
  assign diff = src_a - src_b;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
    localparam int W = MODE_W[g];
    cfu_flag_tap #(.W(W)) u_tap (
      .sign_a (src_a[W-1]),
      .sign_b (src_b[W-1]),
      .diff   (diff[W-1:0]),
      .flags  (mode_flags[g])
    );
  end

  cfu_result_reg #(.MODES(NUM_MODES)) u_result (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .opcode     (opcode),
    .mode_flags (mode_flags),
    .status     (status),
    .valid      (valid),
    .err        (err)
  );

endmodule

// File: rtl/cmp_flag_unit_chk.sv
module cmp_flag_unit_chk
  import cfu_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [OP_W-1:0]    opcode,
  input logic [INSTR_W-1:0] instr,
  input logic [STAT_W-1:0]  status,
  input logic               valid,
  input logic               err
);

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[V_POS-1:0] == '0); // R1

  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    status[Z_POS] |-> !status[N_POS]); // R3

  AST_SELF_COMPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opcode == OP_CMP64 &&
     instr[SRC_A_LSB +: IDX_W] == instr[SRC_B_LSB +: IDX_W])
    |=> (status[Z_POS] && !status[N_POS] && !status[V_POS])); // R2

  AST_VALID_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid); // R9

  AST_VALID_HAS_START: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(start)); // R9

  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(status)); // R9

  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (valid && status == '0)); // R10

  AST_UNKNOWN_OP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opcode != OP_CMP32 && opcode != OP_CMP64) |=> err); // R10

endmodule

bind cmp_flag_unit cmp_flag_unit_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .start  (start),
  .opcode (opcode),
  .instr  (instr),
  .status (status),
  .valid  (valid),
  .err    (err)
);

// File: tb/cmp_flag_unit_tb.sv
`timescale 1ns/1ps
module cmp_flag_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [63:0] wr_data;
  logic        start;
  logic [1:0]  opcode;
  logic [31:0] instr;
  logic [31:0] status;
  logic        valid;
  logic        err;

  typedef struct {
    logic [31:0] stat;
    logic        err;
    string       tag;
  } exp_t;

  exp_t        sb_q [$];
  logic [63:0] mdl [16];
  int          checks;
  int          fails;
  bit          mon_on;
  logic [31:0] last_stat;

  cmp_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .start(start), .opcode(opcode), .instr(instr),
    .status(status), .valid(valid), .err(err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    logic sa, sb, sr, n, z, c, v;
    logic [63:0] r;
    r = a - b;
    if (op == 2'b00) begin
      sa = a[31]; sb = b[31]; sr = r[31]; z = (r[31:0] == 32'h0);
    end else if (op == 2'b01) begin
      sa = a[63]; sb = b[63]; sr = r[63]; z = (r == 64'h0);
    end else begin
      return 32'h0;
    end
    n = sr;
    c = (sa && !sb) || (sa && !sr) || (!sb && !sr);
    v = (sa && !sb && !sr) || (!sa && sb && sr);
    return {n, z, c, v, 28'h0};
  endfunction

  task automatic wr(input logic [3:0] idx, input logic [63:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    mdl[idx] = d;
  endtask

  task automatic cmp(input logic [1:0] op, input logic [3:0] s1, input logic [3:0] s2,
                     input logic [31:0] junk, input string tag);
    exp_t e;
    e.stat = model(op, mdl[s1], mdl[s2]);
    e.err  = (op[1] == 1'b1);
    e.tag  = tag;
    sb_q.push_back(e);
    last_stat = e.stat;
    opcode = op;
    instr  = (junk & 32'hFFF0_FFF0) | {12'h0, s1, 12'h0, s2};
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
  endtask

  // compare and write in the same cycle: compare must see old contents (R12)
  task automatic cmp_with_write(input logic [3:0] s1, input logic [3:0] s2,
                                input logic [63:0] d);
    exp_t e;
    e.stat = model(2'b01, mdl[s1], mdl[s2]);
    e.err  = 1'b0;
    e.tag  = "R12 same-cycle write";
    sb_q.push_back(e);
    last_stat = e.stat;
    opcode = 2'b01;
    instr  = {12'h0, s1, 12'h0, s2};
    start  = 1'b1;
    wr_en  = 1'b1; wr_idx = s1; wr_data = d;
    @(negedge clk);
    start  = 1'b0; wr_en = 1'b0;
    mdl[s1] = d;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R9 unexpected valid", {32'h0, status}, 64'h0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(status == e.stat, e.tag, {32'h0, status}, {32'h0, e.stat});
          check(err == e.err, {e.tag, " R10 err"}, {63'h0, err}, {63'h0, e.err});
          check(status[27:0] == 28'h0, "R1 spare bits", {36'h0, status[27:0]}, 64'h0);
        end
      end else begin
        check(err == 1'b0, "R10 err outside valid", {63'h0, err}, 64'h0);
      end
    end
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; mon_on = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    start = 1'b0; opcode = 2'b00; instr = '0; last_stat = '0;
    for (int i = 0; i < 16; i++) mdl[i] = 64'h0;
    repeat (3) @(negedge clk);
    check(status == 32'h0 && !valid && !err, "R11 in reset", {31'h0, valid, status}, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(status == 32'h0 && !valid && !err, "R11 after release", {31'h0, valid, status}, 64'h0);
    for (int i = 0; i < 16; i++) wr(i[3:0], 64'h0);
    mon_on = 1'b1;

    wr(4'd1, 64'h0000_0000_0000_1234);
    wr(4'd2, 64'h0000_0000_0000_1234);
    wr(4'd3, 64'h0000_0000_0000_5000);
    wr(4'd4, 64'h8000_0000_0000_0000);
    wr(4'd5, 64'h0000_0000_0000_0001);
    wr(4'd6, 64'h7FFF_FFFF_FFFF_FFFF);
    wr(4'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(4'd8, 64'hAAAA_0000_8000_0000);
    wr(4'd9, 64'h5555_0000_8000_0000);
    wr(4'd10, 64'h1234_5678_0000_0001);

    cmp(2'b01, 4'd1, 4'd2, 32'h0, "R2 R7 equal 64");
    cmp(2'b01, 4'd1, 4'd3, 32'h0, "R3 R4 less 64");
    cmp(2'b01, 4'd3, 4'd1, 32'h0, "R4 greater 64");
    cmp(2'b01, 4'd4, 4'd5, 32'h0, "R5 overflow neg-pos 64");
    cmp(2'b01, 4'd6, 4'd7, 32'h0, "R5 overflow pos-neg 64");
    cmp(2'b01, 4'd7, 4'd5, 32'h0, "R4 neg minus pos 64");
    cmp(2'b00, 4'd8, 4'd9, 32'h0, "R6 upper ignored 32");
    cmp(2'b01, 4'd8, 4'd9, 32'h0, "R7 upper used 64");
    cmp(2'b00, 4'd8, 4'd5, 32'h0, "R5 overflow 32");
    cmp(2'b00, 4'd10, 4'd5, 32'h0, "R6 low equal 32");
    cmp(2'b00, 4'd5, 4'd7, 32'h0, "R3 32 sign");
    cmp(2'b01, 4'd3, 4'd1, 32'hFFFF_FFFF, "R8 junk bits");
    cmp(2'b01, 4'd6, 4'd6, 32'hA5A5_A5A5, "R8 same index");
    cmp(2'b10, 4'd3, 4'd1, 32'h0, "R10 opcode 10");
    cmp(2'b11, 4'd4, 4'd5, 32'h0, "R10 opcode 11");
    cmp(2'b01, 4'd1, 4'd3, 32'h0, "R9 back-to-back a");
    cmp(2'b00, 4'd4, 4'd5, 32'h0, "R9 back-to-back b");
    repeat (4) @(negedge clk);
    check(status == last_stat && !valid, "R9 status held", {32'h0, status}, {32'h0, last_stat});

    cmp_with_write(4'd1, 4'd2, 64'h0000_0000_0000_0100);
    cmp(2'b01, 4'd1, 4'd2, 32'h0, "R12 new contents");
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R9 every start answered", sb_q.size(), 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule